// File: doc/BRIEF.md
# Bitwise Request Dispatch Controller

This controller accepts one bulk bitwise request at a time. A request names an operation, an operand count, up to `NSRC` operand row addresses and one destination row address. The controller decodes each operand address into its channel, rank, chip, bank, subarray and row fields. From those fields it picks one of three execution classes. Operands that all sit in one subarray are handled by the sense amplifiers of that subarray. Operands spread over subarrays of one bank are combined in the global row buffer. Operands spread over banks of one chip are combined in the I/O buffer. Operand sets that repeat a row, or that reach past one chip, are refused.

For each accepted request the controller walks through a class-specific list of step commands, followed by a write-back of the result to the destination row. Each step is offered on a valid/ready command port. After a step is accepted, the controller waits for a completion pulse from the unit that executes it before it issues the next step. A one-bit configuration setting selects the cell technology, which sets how many rows a multi-row OR may use. Every request ends with a response that carries a result code and, on success, the execution class.

The controller moves through these states. IDLE accepts a request. CLASSIFY checks it and takes it either to ISSUE or to ERROR. ISSUE goes to WAIT_ACK once the step is accepted. WAIT_ACK goes back to ISSUE for the next step, or to WRITEBACK after the last step, or to DONE after the write-back. WRITEBACK goes to WAIT_ACK. DONE and ERROR both return to IDLE once the response is taken.

Top module: `bwd_dispatch`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid and resp_valid are 0, and the technology setting selects the high-ratio row limit.
- R2: Operand address fields are packed from the least significant bit upward in this order: row (ROW_W bits), subarray (SUB_W), bank (BANK_W), chip (CHIP_W), rank (RANK_W), channel (CH_W).
- R3: When every active operand has the same channel, rank, chip, bank and subarray, the request succeeds with class 0. Its steps are: kind 0 (wordline clear) at operand 0; then kind 1 (row open) at each active operand in slot order; then kind 2 (sense) at operand 0; then kind 7 (write-back) at the destination.
- R4: When all active operands share a bank but at least one subarray differs, the request succeeds with class 1. Its steps are: kind 3 (row-buffer load) at operand 0; then kind 4 (row-buffer merge) at each further operand in slot order; then kind 7 at the destination.
- R5: When all active operands share a chip but at least one bank differs, the request succeeds with class 2. Its steps are: kind 5 (I/O-buffer load) at operand 0; then kind 6 (I/O-buffer merge) at each further operand; then kind 7 at the destination.
- R6: When any active operand differs from operand 0 in chip, rank or channel, the request ends with code 4 and issues no step.
- R7: When two active operands carry the same full address, the request ends with code 3 and issues no step. This check ranks above the cross-chip check.
- R8: The operation codes are 0 OR, 1 AND, 2 XOR and 3 INV. Codes 4 to 7 end with code 1 and no step. This check ranks above every other check.
- R9: INV needs exactly 1 operand, and AND and XOR need exactly 2. OR needs at least 2, at most the row limit, and at most NSRC. Any other count ends with code 2 and no step, and this check ranks above the address checks. Only the first count slots are used for classification.
- R10: A configuration write (cfg_we) stores cfg_low_ratio. A value of 0 gives an OR limit of HI_LIMIT (128), and 1 gives LO_LIMIT (2). The stored value applies to later requests.
- R11: Handshakes are as follows. A command holds its kind and address until cmd_ready. No new command appears before step_ack answers the previous one. A response holds until resp_ready. req_ready is high only when no command or response is pending.
- R12: A success reports code 0 after the write-back step is acknowledged. A refusal reports class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_low_ratio | input | 1 | Technology select: 1 means low on/off ratio |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken when high with req_valid |
| req_op | input | 3 | Operation code |
| req_cnt | input | CNT_W | Operand count |
| req_src | input | NSRC*AW | Operand addresses, slot 0 in the low bits |
| req_dst | input | AW | Destination row address |
| cmd_valid | output | 1 | Step command offered |
| cmd_ready | input | 1 | Step command taken |
| cmd_kind | output | 3 | Step kind |
| cmd_op | output | 3 | Operation of the running request |
| cmd_addr | output | AW | Row address for the step |
| step_ack | input | 1 | Completion pulse for the accepted step |
| resp_valid | output | 1 | Response offered |
| resp_ready | input | 1 | Response taken |
| resp_code | output | 3 | 0 ok, 1 bad op, 2 bad count, 3 repeated row, 4 cross chip |
| resp_class | output | 2 | 0 intra-subarray, 1 inter-subarray, 2 inter-bank |

## Verification
The bench sweeps every operation code against every operand count from 0 to NSRC+1, under both technology settings and over address patterns built to hit each class. The sweep includes a repeated row, a cross-chip slot, a repeated row together with a cross-chip slot, and a cross-chip address parked in an inactive slot. A design that compared inactive slots would refuse valid requests. A design that ranked the checks wrongly would report the wrong refusal code. A design that kept the OR limit at 128 on low-ratio cells would accept three-row OR requests that it must refuse. Stalling the ready and acknowledge inputs catches a controller that changes a pending command, or that issues the next step before the previous one completes. Two directed cases separate row bits from subarray bits and subarray bits from bank bits, which catches a misplaced field boundary.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLASSIFY,
        ST_ISSUE,
        ST_WAIT_ACK,
        ST_WRITEBACK,
        ST_DONE,
        ST_ERROR
    } state_t;

    typedef enum logic [1:0] {
        CL_INTRA     = 2'd0,
        CL_INTERSUB  = 2'd1,
        CL_INTERBANK = 2'd2
    } class_t;

    localparam logic [2:0] OP_OR  = 3'd0;
    localparam logic [2:0] OP_AND = 3'd1;
    localparam logic [2:0] OP_XOR = 3'd2;
    localparam logic [2:0] OP_INV = 3'd3;

    localparam logic [2:0] K_WL_CLEAR  = 3'd0;
    localparam logic [2:0] K_ROW_OPEN  = 3'd1;
    localparam logic [2:0] K_SENSE     = 3'd2;
    localparam logic [2:0] K_GRB_LOAD  = 3'd3;
    localparam logic [2:0] K_GRB_MERGE = 3'd4;
    localparam logic [2:0] K_IOB_LOAD  = 3'd5;
    localparam logic [2:0] K_IOB_MERGE = 3'd6;
    localparam logic [2:0] K_WRITE     = 3'd7;

    localparam logic [2:0] RC_OK       = 3'd0;
    localparam logic [2:0] RC_BAD_OP   = 3'd1;
    localparam logic [2:0] RC_BAD_CNT  = 3'd2;
    localparam logic [2:0] RC_SAME_ROW = 3'd3;
    localparam logic [2:0] RC_FAR      = 3'd4;

endpackage

// File: rtl/bwd_classify.sv
module bwd_classify
    import bwd_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int CNT_W    = 8,
    parameter int ROW_W    = 4,
    parameter int SUB_W    = 2,
    parameter int BANK_W   = 2,
    parameter int UP_W     = 3,
    parameter int HI_LIMIT = 128,
    parameter int LO_LIMIT = 2,
    localparam int AW      = ROW_W + SUB_W + BANK_W + UP_W
) (
    input  logic [2:0]          op,
    input  logic [CNT_W-1:0]    cnt,
    input  logic                low_ratio,
    input  logic [NSRC*AW-1:0]  srcs,
    output logic [2:0]          code,
    output class_t              cls
);
    localparam int SUB_LO  = ROW_W;
    localparam int BANK_LO = ROW_W + SUB_W;
    localparam int UP_LO   = BANK_LO + BANK_W;
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);
    localparam logic [CNT_W-1:0] C_SLT = CNT_W'(NSRC);
    localparam logic [CNT_W-1:0] C_HI  = CNT_W'(HI_LIMIT);
    localparam logic [CNT_W-1:0] C_LO  = CNT_W'(LO_LIMIT);

    logic [AW-1:0]    src [NSRC];
    logic [NSRC-1:0]  act;
    logic             dup, far, bank_diff, sub_diff, cnt_ok;
    logic [CNT_W-1:0] or_lim, or_cap;

    for (genvar g = 0; g < NSRC; g++) begin : g_slot
        assign src[g] = srcs[g*AW +: AW];
        assign act[g] = CNT_W'(g) < cnt;
    end

    always_comb begin
        dup       = 1'b0;
        far       = 1'b0;
        bank_diff = 1'b0;
        sub_diff  = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            for (int j = i + 1; j < NSRC; j++) begin
                if (act[j] && (src[i] == src[j])) dup = 1'b1;
            end
        end
        for (int j = 1; j < NSRC; j++) begin
            if (act[j]) begin
                if (src[j][AW-1:UP_LO] != src[0][AW-1:UP_LO])           far       = 1'b1;
                if (src[j][UP_LO-1:BANK_LO] != src[0][UP_LO-1:BANK_LO]) bank_diff = 1'b1;
                if (src[j][BANK_LO-1:SUB_LO] != src[0][BANK_LO-1:SUB_LO]) sub_diff = 1'b1;
            end
        end
    end

    always_comb begin
        or_lim = low_ratio ? C_LO : C_HI;
        or_cap = (or_lim < C_SLT) ? or_lim : C_SLT;
        unique case (op)
            OP_OR:          cnt_ok = (cnt >= C_TWO) && (cnt <= or_cap);
            OP_AND, OP_XOR: cnt_ok = (cnt == C_TWO) && (C_TWO <= C_SLT);
            OP_INV:         cnt_ok = (cnt == C_ONE);
            default:        cnt_ok = 1'b0;
        endcase
        if (op[2])        code = RC_BAD_OP;
        else if (!cnt_ok) code = RC_BAD_CNT;
        else if (dup)     code = RC_SAME_ROW;
        else if (far)     code = RC_FAR;
        else              code = RC_OK;
        if (bank_diff)     cls = CL_INTERBANK;
        else if (sub_diff) cls = CL_INTERSUB;
        else               cls = CL_INTRA;
    end

endmodule

// File: rtl/bwd_stepgen.sv
module bwd_stepgen
    import bwd_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int AW    = 11,
    localparam int IDX_W = $clog2(NSRC + 2)
) (
    input  class_t              cls,
    input  logic [IDX_W-1:0]    idx,
    input  logic [IDX_W-1:0]    cnt,
    input  logic [NSRC*AW-1:0]  srcs,
    output logic [2:0]          kind,
    output logic [AW-1:0]       addr,
    output logic                last
);
    logic [IDX_W-1:0] sel;
    logic [AW-1:0]    pick, first;

    always_comb begin
        first = srcs[AW-1:0];
        sel   = (cls == CL_INTRA) ? (idx - IDX_W'(1)) : idx;
        pick  = first;
        for (int i = 0; i < NSRC; i++) begin
            if (IDX_W'(i) == sel) pick = srcs[i*AW +: AW];
        end
        unique case (cls)
            CL_INTRA: begin
                if (idx == '0) begin
                    kind = K_WL_CLEAR;
                    addr = first;
                    last = 1'b0;
                end else if (idx == cnt + IDX_W'(1)) begin
                    kind = K_SENSE;
                    addr = first;
                    last = 1'b1;
                end else begin
                    kind = K_ROW_OPEN;
                    addr = pick;
                    last = 1'b0;
                end
            end
            CL_INTERSUB: begin
                kind = (idx == '0) ? K_GRB_LOAD : K_GRB_MERGE;
                addr = pick;
                last = (idx == cnt - IDX_W'(1));
            end
            default: begin
                kind = (idx == '0) ? K_IOB_LOAD : K_IOB_MERGE;
                addr = pick;
                last = (idx == cnt - IDX_W'(1));
            end
        endcase
    end

endmodule

// File: rtl/bwd_dispatch.sv
module bwd_dispatch
    import bwd_pkg::*;
#(
    parameter int NSRC     = 4,
    parameter int CNT_W    = 8,
    parameter int ROW_W    = 4,
    parameter int SUB_W    = 2,
    parameter int BANK_W   = 2,
    parameter int CHIP_W   = 1,
    parameter int RANK_W   = 1,
    parameter int CH_W     = 1,
    parameter int HI_LIMIT = 128,
    parameter int LO_LIMIT = 2,
    localparam int UP_W    = CHIP_W + RANK_W + CH_W,
    localparam int AW      = ROW_W + SUB_W + BANK_W + UP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic                cfg_low_ratio,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [2:0]          req_op,
    input  logic [CNT_W-1:0]    req_cnt,
    input  logic [NSRC*AW-1:0]  req_src,
    input  logic [AW-1:0]       req_dst,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic [2:0]          cmd_kind,
    output logic [2:0]          cmd_op,
    output logic [AW-1:0]       cmd_addr,
    input  logic                step_ack,
    output logic                resp_valid,
    input  logic                resp_ready,
    output logic [2:0]          resp_code,
    output logic [1:0]          resp_class
);
    localparam int IDX_W = $clog2(NSRC + 2);

    state_t               state, state_nx;
    logic [2:0]           op_q, code_q, cl_code;
    logic [CNT_W-1:0]     cnt_q;
    logic [NSRC*AW-1:0]   src_q;
    logic [AW-1:0]        dst_q, sg_addr;
    logic                 low_q, wb_q, sg_last;
    class_t               cls_q, cl_cls;
    logic [IDX_W-1:0]     idx_q;
    logic [2:0]           sg_kind;

    bwd_classify #(
        .NSRC(NSRC), .CNT_W(CNT_W), .ROW_W(ROW_W), .SUB_W(SUB_W),
        .BANK_W(BANK_W), .UP_W(UP_W), .HI_LIMIT(HI_LIMIT), .LO_LIMIT(LO_LIMIT)
    ) u_cls (
        .op(op_q), .cnt(cnt_q), .low_ratio(low_q), .srcs(src_q),
        .code(cl_code), .cls(cl_cls)
    );

    bwd_stepgen #(.NSRC(NSRC), .AW(AW)) u_steps (
        .cls(cls_q), .idx(idx_q), .cnt(cnt_q[IDX_W-1:0]), .srcs(src_q),
        .kind(sg_kind), .addr(sg_addr), .last(sg_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req_valid) state_nx = ST_CLASSIFY;
            ST_CLASSIFY:  state_nx = (cl_code != RC_OK) ? ST_ERROR : ST_ISSUE;
            ST_ISSUE:     if (cmd_ready) state_nx = ST_WAIT_ACK;
            ST_WAIT_ACK: begin
                if (step_ack) begin
                    if (wb_q)         state_nx = ST_DONE;
                    else if (sg_last) state_nx = ST_WRITEBACK;
                    else              state_nx = ST_ISSUE;
                end
            end
            ST_WRITEBACK: if (cmd_ready) state_nx = ST_WAIT_ACK;
            ST_DONE,
            ST_ERROR:     if (resp_ready) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_q  <= 1'b0;
            op_q   <= '0;
            cnt_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            code_q <= RC_OK;
            cls_q  <= CL_INTRA;
            idx_q  <= '0;
            wb_q   <= 1'b0;
        end else begin
            if (cfg_we) low_q <= cfg_low_ratio;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    op_q  <= req_op;
                    cnt_q <= req_cnt;
                    src_q <= req_src;
                    dst_q <= req_dst;
                    wb_q  <= 1'b0;
                end
                ST_CLASSIFY: begin
                    code_q <= cl_code;
                    cls_q  <= (cl_code == RC_OK) ? cl_cls : CL_INTRA;
                    idx_q  <= '0;
                end
                ST_WAIT_ACK: if (step_ack && !wb_q && !sg_last) idx_q <= idx_q + IDX_W'(1);
                ST_WRITEBACK: if (cmd_ready) wb_q <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        cmd_valid  = (state == ST_ISSUE) || (state == ST_WRITEBACK);
        cmd_kind   = (state == ST_WRITEBACK) ? K_WRITE : sg_kind;
        cmd_addr   = (state == ST_WRITEBACK) ? dst_q : sg_addr;
        cmd_op     = op_q;
        resp_valid = (state == ST_DONE) || (state == ST_ERROR);
        resp_code  = (state == ST_ERROR) ? code_q : RC_OK;
        resp_class = (state == ST_DONE) ? cls_q : CL_INTRA;
    end

endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [2:0]    cmd_kind,
    input logic [AW-1:0] cmd_addr,
    input logic          step_ack,
    input logic          resp_valid,
    input logic          resp_ready,
    input logic [2:0]    resp_code,
    input logic [1:0]    resp_class
);
    logic       steps_seen, await_ack;
    logic [2:0] last_kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            steps_seen <= 1'b0;
            await_ack  <= 1'b0;
            last_kind  <= 3'd0;
        end else begin
            if (req_valid && req_ready) steps_seen <= 1'b0;
            if (cmd_valid && cmd_ready) begin
                steps_seen <= 1'b1;
                await_ack  <= 1'b1;
                last_kind  <= cmd_kind;
            end else if (step_ack) begin
                await_ack <= 1'b0;
            end
        end
    end

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !resp_valid)); // R11
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_addr))); // R11
    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_code) && $stable(resp_class))); // R11
    AST_NO_CMD_BEFORE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !await_ack); // R11
    AST_REFUSE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code != 3'd0) |-> !steps_seen); // R8
    AST_REFUSE_CLASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code != 3'd0) |-> (resp_class == 2'd0)); // R12
    AST_OK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 3'd0) |-> (steps_seen && last_kind == 3'd7 && !await_ack)); // R12

endmodule

bind bwd_dispatch bwd_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .step_ack(step_ack), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_code(resp_code), .resp_class(resp_class)
);

// File: tb/sim_bwd_dispatch.sv
module sim_bwd_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 4;
    localparam int AW    = 11;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n, cfg_we, cfg_low_ratio, req_valid, req_ready;
    logic [2:0] req_op, cmd_kind, cmd_op, resp_code;
    logic [CNT_W-1:0] req_cnt;
    logic [NSRC*AW-1:0] req_src;
    logic [AW-1:0] req_dst, cmd_addr;
    logic cmd_valid, cmd_ready, step_ack, resp_valid, resp_ready;
    logic [1:0] resp_class;

    bwd_dispatch u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_low_ratio(cfg_low_ratio),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_cnt(req_cnt),
        .req_src(req_src), .req_dst(req_dst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .step_ack(step_ack),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_code(resp_code),
        .resp_class(resp_class)
    );

    int checks = 0;
    int fails  = 0;
    int tick   = 0;

    logic [AW-1:0] s [NSRC];
    logic [AW-1:0] dst;
    int            n_obs;
    logic [2:0]    obs_kind [16];
    logic [AW-1:0] obs_addr [16];
    int            n_exp;
    logic [2:0]    exp_kind [16];
    logic [AW-1:0] exp_addr [16];
    logic [2:0]    got_code;
    logic [1:0]    got_cls;
    bit            got_resp;
    int            hold_err, ack_err;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R2 layout: row[3:0], subarray[5:4], bank[7:6], chip 8, rank 9, channel 10
    function automatic logic [AW-1:0] mk(input int up, input int bank, input int sub, input int row);
        return AW'((up % 8) * 256 + (bank % 4) * 64 + (sub % 4) * 16 + (row % 16));
    endfunction

    function automatic void expect_outcome(input int op, input int cnt, input bit low,
                                           output int code, output int cls);
        int lim;
        bit ok, dup, far, bd, sd;
        lim = low ? 2 : 128;
        if (lim > NSRC) lim = NSRC;
        case (op)
            0: ok = (cnt >= 2) && (cnt <= lim);
            1, 2: ok = (cnt == 2);
            3: ok = (cnt == 1);
            default: ok = 0;
        endcase
        dup = 0; far = 0; bd = 0; sd = 0;
        if (op <= 3 && ok) begin
            for (int i = 0; i < cnt; i++)
                for (int j = i + 1; j < cnt; j++)
                    if (s[i] == s[j]) dup = 1;
            for (int j = 1; j < cnt; j++) begin
                if ((int'(s[j]) / 256) != (int'(s[0]) / 256)) far = 1;
                if (((int'(s[j]) / 64) % 4) != ((int'(s[0]) / 64) % 4)) bd = 1;
                if (((int'(s[j]) / 16) % 4) != ((int'(s[0]) / 16) % 4)) sd = 1;
            end
        end
        if (op > 3) code = 1;
        else if (!ok) code = 2;
        else if (dup) code = 3;
        else if (far) code = 4;
        else code = 0;
        cls = (code != 0) ? 0 : (bd ? 2 : (sd ? 1 : 0));
    endfunction

    function automatic void build_steps(input int cls, input int cnt);
        n_exp = 0;
        if (cls == 0) begin
            exp_kind[n_exp] = 3'd0; exp_addr[n_exp] = s[0]; n_exp++;
            for (int i = 0; i < cnt; i++) begin
                exp_kind[n_exp] = 3'd1; exp_addr[n_exp] = s[i]; n_exp++;
            end
            exp_kind[n_exp] = 3'd2; exp_addr[n_exp] = s[0]; n_exp++;
        end else begin
            for (int i = 0; i < cnt; i++) begin
                exp_kind[n_exp] = (cls == 1) ? ((i == 0) ? 3'd3 : 3'd4)
                                             : ((i == 0) ? 3'd5 : 3'd6);
                exp_addr[n_exp] = s[i]; n_exp++;
            end
        end
        exp_kind[n_exp] = 3'd7; exp_addr[n_exp] = dst; n_exp++;
    endfunction

    task automatic run_req(input int op, input int cnt);
        bit waiting, stalled, done;
        int delay;
        logic [2:0] pk;
        logic [AW-1:0] pa;
        n_obs = 0; hold_err = 0; ack_err = 0; got_resp = 0;
        waiting = 0; stalled = 0; done = 0; delay = 0; pk = '0; pa = '0;
        @(negedge clk);
        req_op = 3'(op); req_cnt = CNT_W'(cnt);
        req_src = {s[3], s[2], s[1], s[0]}; req_dst = dst; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 400 && !done; c++) begin
            tick++;
            step_ack = 1'b0;
            if (resp_ready) begin
                resp_ready = 1'b0;
                done = 1;
            end else begin
                if (cmd_valid && waiting) ack_err++;
                if (waiting) begin
                    if (delay == 0) begin step_ack = 1'b1; waiting = 0; end
                    else delay--;
                end
                if (cmd_valid) begin
                    if (stalled && (cmd_kind != pk || cmd_addr != pa)) hold_err++;
                    if (tick % 3 != 0) begin
                        cmd_ready = 1'b1;
                        if (n_obs < 16) begin
                            obs_kind[n_obs] = cmd_kind; obs_addr[n_obs] = cmd_addr;
                        end
                        n_obs++;
                        waiting = 1; delay = tick % 2; stalled = 0;
                    end else begin
                        cmd_ready = 1'b0; stalled = 1; pk = cmd_kind; pa = cmd_addr;
                    end
                end else begin
                    if (stalled) hold_err++;
                    cmd_ready = 1'b0; stalled = 0;
                end
                if (resp_valid && (tick % 2 == 0)) begin
                    resp_ready = 1'b1; got_code = resp_code; got_cls = resp_class; got_resp = 1;
                end
                @(negedge clk);
            end
        end
        cmd_ready = 1'b0; step_ack = 1'b0;
    endtask

    task automatic judge(input int op, input int cnt, input bit low);
        int ec, ecls, bad;
        string tag;
        expect_outcome(op, cnt, low, ec, ecls);
        case (ec)
            1: tag = "R8 bad op";
            2: tag = "R9 bad count";
            3: tag = "R7 repeated row";
            4: tag = "R6 cross chip";
            default: tag = (ecls == 0) ? "R3 intra" : ((ecls == 1) ? "R4 inter-sub" : "R5 inter-bank");
        endcase
        chk(got_resp, {tag, " response seen"}, int'(got_resp), 1);
        chk(got_code == 3'(ec), {tag, " code"}, int'(got_code), ec);
        chk(got_cls == 2'(ecls), {tag, " R12 class"}, int'(got_cls), ecls);
        if (ec == 0) build_steps(ecls, cnt); else n_exp = 0;
        chk(n_obs == n_exp, {tag, " step count"}, n_obs, n_exp);
        bad = -1;
        if (n_obs == n_exp)
            for (int i = 0; i < n_exp; i++)
                if (bad < 0 && (obs_kind[i] != exp_kind[i] || obs_addr[i] != exp_addr[i])) bad = i;
        chk(bad < 0, {tag, " step content (index)"}, bad, -1);
        chk(hold_err == 0 && ack_err == 0, "R11 handshake", hold_err + ack_err, 0);
    endtask

    task automatic fill(input int p);
        int u, b, sb, bit_sel;
        u = $urandom_range(0, 7); b = $urandom_range(0, 3); sb = $urandom_range(0, 3);
        bit_sel = $urandom_range(0, 2);
        for (int i = 0; i < NSRC; i++) begin
            case (p)
                0: s[i] = mk(u, b, sb, i + 1);
                1: s[i] = mk(u, b, sb + i, 3);
                2: s[i] = mk(u, b + i, sb, 5);
                3: s[i] = mk(u, b, sb, (i == 1) ? 1 : i + 1);
                4: s[i] = mk((i == 1) ? (u ^ (1 << bit_sel)) : u, b, sb, i + 1);
                5: s[i] = mk((i == 3) ? (u ^ (1 << bit_sel)) : u, b, sb, i + 1);
                6: s[i] = mk((i == 2) ? (u ^ 1) : u, b, sb, (i == 1) ? 1 : i + 1);
                default: s[i] = AW'($urandom_range(0, 2047));
            endcase
        end
        dst = AW'($urandom_range(0, 2047));
    endtask

    task automatic cfg_write(input bit v);
        @(negedge clk); cfg_we = 1'b1; cfg_low_ratio = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_low_ratio = 1'b0; req_valid = 1'b0;
        req_op = '0; req_cnt = '0; req_src = '0; req_dst = '0;
        cmd_ready = 1'b0; step_ack = 1'b0; resp_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R1 cmd_valid after reset", int'(cmd_valid), 0);
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", int'(resp_valid), 0);

        // R1 / R10: first sweep relies on the reset technology setting (high ratio)
        for (int low = 0; low < 2; low++) begin
            if (low == 1) cfg_write(1'b1);
            for (int p = 0; p < 8; p++)
                for (int op = 0; op < 8; op++)
                    for (int cnt = 0; cnt <= NSRC + 1; cnt++) begin
                        fill(p);
                        run_req(op, cnt);
                        judge(op, cnt, bit'(low));
                    end
        end

        // R10: three-row OR refused on low ratio, accepted once high ratio is written back
        fill(0);
        run_req(0, 3);
        chk(got_code == 3'd2, "R10 low-ratio three-row OR", int'(got_code), 2);
        cfg_write(1'b0);
        run_req(0, 3);
        chk(got_code == 3'd0, "R10 high-ratio three-row OR", int'(got_code), 0);

        // R2: row top bit versus subarray low bit, subarray top bit versus bank low bit
        s[0] = mk(0, 0, 0, 15); s[1] = mk(0, 0, 1, 0); s[2] = mk(0, 0, 0, 1); s[3] = mk(0, 0, 0, 2);
        dst = mk(0, 0, 0, 9);
        run_req(0, 2);
        chk(got_code == 3'd0 && got_cls == 2'd1, "R2 subarray field", int'(got_cls), 1);
        s[1] = mk(0, 1, 0, 0); s[0] = mk(0, 0, 3, 0);
        run_req(1, 2);
        chk(got_code == 3'd0 && got_cls == 2'd2, "R2 bank field", int'(got_cls), 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule